// File: doc/BRIEF.md
# Prescaled 64-bit Compare Timer

This block is a machine timer for a single hart with a single timer. A 64-bit time counter moves forward by a programmable step on every tick of a prescaler. The counter runs only while a control flag is set. When the counter is equal to or greater than a 64-bit compare value, a sticky status bit is set. An enable bit routes that status bit to an interrupt pin. Software can also inject the status bit through a write-only test register.

Software reaches every register through a plain 32-bit register port. A request is carried by `reg_req`, and `reg_we` marks it as a write. The port never stalls, so there is no back-pressure: a write takes effect at the clock edge that samples it. Read data is combinational and is valid in the same cycle as the request. There is no data stream at the edge of the block, so there is no valid/ready interface.

Top module: `tick_timer`

## Requirements
- R1: After reset the following values read back: control = 0, config = 0x00010000 (prescale 0, step 1), time lower/upper = 0, compare lower/upper = 0xFFFFFFFF, interrupt enable = 0, status = 0. `irq` is 0.
- R2: Control bit 0 at address 0x000 is the run flag. While it is 0 the time value holds and the prescaler count is held at 0.
- R3: While running, the prescaler issues one tick every prescale+1 cycles. The first tick comes on the (prescale+1)-th running clock edge. Prescale is config bits [11:0] at address 0x10C, and a prescale of 0 ticks on every cycle.
- R4: On each tick the 64-bit time value adds the zero-extended step. The step is config bits [23:16]. The sum wraps modulo 2^64.
- R5: Time lower (0x110, bits [31:0]) and time upper (0x114, bits [63:32]) are readable and writable. A software write to either half replaces that half. The write wins over a tick in the same cycle.
- R6: When the 64-bit time value is greater than or equal to the 64-bit compare value, status bit 0 at 0x104 is set on the next clock edge. Compare lower is at 0x118 and compare upper is at 0x11C.
- R7: Writing 1 to status bit 0 clears it, but only if the expiry condition no longer holds. While expired, the bit is set again every cycle.
- R8: `irq` equals status bit 0 AND enable bit 0. The enable register is at 0x100.
- R9: Writing 1 to bit 0 of the test register at 0x108 sets the status bit. The test register always reads 0.
- R10: Reads of unmapped addresses return 0. Writes to unmapped addresses change no register.
- R11: The config register reads back prescale in bits [11:0] and step in bits [23:16]. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access request this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the request cycle |
| irq | output | 1 | Timer interrupt (status AND enable) |

## Verification
The bench builds the block with its default widths: a 12-bit prescale field, an 8-bit step field and 32-bit register halves. A prescale of 3 with a step of 5 checks the tick division. A step of 3 applied just below 2^64 checks the wrap, which carries out of the lower half and through the top. An upper-half time of 1 against a compare of 0x00000000_00000064 shows that expiry is judged on the full 64 bits, not on the lower half alone.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_RUN   = 12'h000;
  localparam logic [ADDR_W-1:0] A_IEN   = 12'h100;
  localparam logic [ADDR_W-1:0] A_IST   = 12'h104;
  localparam logic [ADDR_W-1:0] A_ITEST = 12'h108;
  localparam logic [ADDR_W-1:0] A_CFG   = 12'h10C;
  localparam logic [ADDR_W-1:0] A_TLO   = 12'h110;
  localparam logic [ADDR_W-1:0] A_THI   = 12'h114;
  localparam logic [ADDR_W-1:0] A_CLO   = 12'h118;
  localparam logic [ADDR_W-1:0] A_CHI   = 12'h11C;

  localparam int unsigned PRE_LSB  = 0;
  localparam int unsigned STEP_LSB = 16;
endpackage

// File: rtl/tick_timer_prescaler.sv
module tick_timer_prescaler #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;

  // ">=" keeps the count bounded if the limit is lowered while running
  assign tick = run && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tick_timer_counter.sv
module tick_timer_counter #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned STEP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [STEP_W-1:0]   step,
  input  logic [1:0]          wr_half,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] value
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] val_q;
  logic [CNT_W-1:0] sw_val;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign sw_val[h*HALF_W +: HALF_W] = wr_half[h] ? wdata : val_q[h*HALF_W +: HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          val_q <= '0;
    else if (|wr_half)   val_q <= sw_val;
    else if (tick)       val_q <= val_q + {{(CNT_W-STEP_W){1'b0}}, step};
  end

  assign value = val_q;
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned PRE_W    = 12,
  parameter int unsigned STEP_W   = 8,
  parameter int unsigned STEP_RST = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  input  logic [2*REG_W-1:0]  time_val,
  input  logic                expired,
  output logic                run,
  output logic [PRE_W-1:0]    prescale,
  output logic [STEP_W-1:0]   step,
  output logic [1:0]          time_wr,
  output logic [2*REG_W-1:0]  cmp_val,
  output logic                irq
);
  logic             ien_q, ist_q;
  logic [REG_W-1:0] rdata_mux;

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return req && we && (addr == a);
  endfunction

  assign time_wr = {hit(A_THI), hit(A_TLO)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      prescale <= '0;
      step     <= STEP_W'(STEP_RST);
      cmp_val  <= '1;
      ien_q    <= 1'b0;
    end else begin
      if (hit(A_RUN)) run <= wdata[0];
      if (hit(A_CFG)) begin
        prescale <= wdata[PRE_LSB +: PRE_W];
        step     <= wdata[STEP_LSB +: STEP_W];
      end
      if (hit(A_CLO)) cmp_val[REG_W-1:0]       <= wdata;
      if (hit(A_CHI)) cmp_val[2*REG_W-1:REG_W] <= wdata;
      if (hit(A_IEN)) ien_q <= wdata[0];
    end
  end

  // set sources (expiry, test injection) win over write-1-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ist_q <= 1'b0;
    else if (expired || (hit(A_ITEST) && wdata[0])) ist_q <= 1'b1;
    else if (hit(A_IST) && wdata[0])         ist_q <= 1'b0;
  end

  assign irq = ist_q & ien_q;

  always_comb begin
    rdata_mux = '0;
    if (req && !we) begin
      case (addr)
        A_RUN: rdata_mux[0] = run;
        A_IEN: rdata_mux[0] = ien_q;
        A_IST: rdata_mux[0] = ist_q;
        A_CFG: begin
          rdata_mux[PRE_LSB +: PRE_W]   = prescale;
          rdata_mux[STEP_LSB +: STEP_W] = step;
        end
        A_TLO: rdata_mux = time_val[REG_W-1:0];
        A_THI: rdata_mux = time_val[2*REG_W-1:REG_W];
        A_CLO: rdata_mux = cmp_val[REG_W-1:0];
        A_CHI: rdata_mux = cmp_val[2*REG_W-1:REG_W];
        default: rdata_mux = '0;
      endcase
    end
  end

  assign rdata = rdata_mux;
  logic [REG_W-1:0] rdata;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned PRE_W    = 12,
  parameter int unsigned STEP_W   = 8,
  parameter int unsigned STEP_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int unsigned CNT_W = 2 * REG_W;

  logic              run;
  logic [PRE_W-1:0]  prescale;
  logic [STEP_W-1:0] step;
  logic [1:0]        time_wr;
  logic [CNT_W-1:0]  time_val;
  logic [CNT_W-1:0]  cmp_val;
  logic              tick;
  logic              expired;

  assign expired = (time_val >= cmp_val);

  tick_timer_regs #(
    .PRE_W(PRE_W), .STEP_W(STEP_W), .STEP_RST(STEP_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req(reg_req), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .time_val(time_val), .expired(expired),
    .run(run), .prescale(prescale), .step(step),
    .time_wr(time_wr), .cmp_val(cmp_val), .irq(irq)
  );

  assign reg_rdata = u_regs.rdata;

  tick_timer_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .limit(prescale), .tick(tick)
  );

  tick_timer_counter #(.HALF_W(REG_W), .STEP_W(STEP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step(step),
    .wr_half(time_wr), .wdata(reg_wdata), .value(time_val)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int unsigned STEP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_req,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              run,
  input logic              tick,
  input logic [STEP_W-1:0] step,
  input logic [2*REG_W-1:0] time_val,
  input logic [2*REG_W-1:0] cmp_val,
  input logic              irq,
  input logic              ist,
  input logic              ien
);
  logic tw, tst;
  assign tw  = reg_req && reg_we && (reg_addr == A_TLO || reg_addr == A_THI);
  assign tst = reg_req && reg_we && (reg_addr == A_ITEST) && reg_wdata[0];

  // R2
  counter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !tw) |=> $stable(time_val));

  // R3
  tick_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  // R4
  step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !tw) |=> (time_val == $past(time_val) + {{(2*REG_W-STEP_W){1'b0}}, $past(step)}));

  // R6
  expire_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_val >= cmp_val) |=> ist);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

  // R9
  test_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tst |=> ist);
endmodule

bind tick_timer tick_timer_chk #(.STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .run(run), .tick(tick),
  .step(step), .time_val(time_val), .cmp_val(cmp_val), .irq(irq),
  .ist(u_regs.ist_q), .ien(u_regs.ien_q)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
  import tick_timer_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_req = 1'b0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [REG_W-1:0]  reg_rdata;
  logic              irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [REG_W-1:0] exp;
    string            tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_req = 1'b0; reg_we = 1'b0;
    end
  endtask

  // driver: issue a read and push the expected value to the scoreboard
  task automatic rd(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
    #1;
    check(tag, {31'd0, irq}, {31'd0, e});
  endtask

  // monitor: pop expected items and compare with read data
  initial begin
    exp_t it;
    forever begin
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      check(it.tag, reg_rdata, it.exp);
    end
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    chk_irq(1'b0, "R1 irq");
    rd(A_RUN, 32'h0, "R1 run");
    rd(A_CFG, 32'h0001_0000, "R1 cfg");
    rd(A_CLO, 32'hFFFF_FFFF, "R1 cmp lo");
    rd(A_CHI, 32'hFFFF_FFFF, "R1 cmp hi");
    rd(A_TLO, 32'h0, "R1 time lo");
    rd(A_THI, 32'h0, "R1 time hi");
    rd(A_IST, 32'h0, "R1 status");
    rd(A_IEN, 32'h0, "R1 enable");
    // R2 hold while stopped
    idle(20);
    rd(A_TLO, 32'h0, "R2 hold");
    // R3 R4 prescale 0 step 1: 10 running edges
    wr(A_RUN, 1); idle(9); wr(A_RUN, 0);
    rd(A_TLO, 32'd10, "R3 prescale0");
    // R3 prescale 3 step 5: 12 running edges -> 3 ticks
    wr(A_CFG, (32'd5 << 16) | 32'd3);
    wr(A_TLO, 0);
    wr(A_RUN, 1); idle(11); wr(A_RUN, 0);
    rd(A_TLO, 32'd15, "R3 prescale3");
    rd(A_CFG, 32'h0005_0003, "R11 cfg fields");
    // R5 write beats tick
    wr(A_CFG, 32'h0001_0000);
    wr(A_RUN, 1); wr(A_TLO, 32'd100);
    rd(A_TLO, 32'd100, "R5 write priority");
    wr(A_RUN, 0);
    // R4 wrap
    wr(A_CFG, 32'h0003_0000);
    wr(A_THI, 32'hFFFF_FFFF); wr(A_TLO, 32'hFFFF_FFFE);
    wr(A_RUN, 1); wr(A_RUN, 0);
    rd(A_TLO, 32'd1, "R4 wrap lo");
    rd(A_THI, 32'd0, "R4 wrap hi");
    rd(A_IST, 32'd0, "R6 not expired");
    // R6 expiry at equality
    wr(A_CHI, 0); wr(A_CLO, 32'd10);
    wr(A_TLO, 32'd9); idle(2);
    rd(A_IST, 32'd0, "R6 below compare");
    wr(A_TLO, 32'd10); idle(1);
    rd(A_IST, 32'd1, "R6 equal compare");
    // R8 gating
    chk_irq(1'b0, "R8 disabled");
    wr(A_IEN, 1);
    chk_irq(1'b1, "R8 enabled");
    // R7 clear only after expiry ends
    wr(A_IST, 1); idle(1);
    rd(A_IST, 32'd1, "R7 reset while expired");
    wr(A_CLO, 32'd100); wr(A_IST, 1); idle(1);
    rd(A_IST, 32'd0, "R7 cleared");
    chk_irq(1'b0, "R8 cleared");
    // R9 test injection
    wr(A_ITEST, 1); idle(1);
    rd(A_IST, 32'd1, "R9 inject");
    rd(A_ITEST, 32'd0, "R9 reads zero");
    chk_irq(1'b1, "R9 irq");
    wr(A_IST, 1); idle(1);
    rd(A_IST, 32'd0, "R9 clear");
    // R10 unmapped
    wr(12'h200, 32'hDEAD_BEEF); wr(12'h120, 32'h1234_5678);
    rd(12'h200, 32'd0, "R10 unmapped read");
    rd(A_CLO, 32'd100, "R10 cmp unchanged");
    rd(A_RUN, 32'd0, "R10 run unchanged");
    // R6 full 64-bit compare
    wr(A_THI, 32'd1); wr(A_TLO, 32'd0); idle(1);
    rd(A_IST, 32'd1, "R6 upper half");
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule